// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This block gathers 96 interrupt sources into three 32-bit banks and presents them to a processor through one request line and a small register space on a 32-bit bus. Every source has its own pending, enable and mask bit. A vector register names the lowest-numbered source that is pending, enabled and not masked. Software reads that vector to pick a handler, then clears the pending bit by writing a one to it.

Source 0 is the external non-maskable input. It is edge-captured and stays pending until software clears it. Sources 1 to 95 are level inputs. A vector value of zero means either that nothing is active or that source 0 is active. Software separates the two cases by reading bit 0 of pending bank 0. The block also has a one-bit protection register and a two-bit external-input control register. Both are plain storage that reads back what was written.

Writes take effect on the rising clock edge when `wr_en` is high. Reads are combinational from `addr`.

Top module: `irq_vector_ctl`

## Requirements
- R1: After reset, all pending, enable and mask bits are 0, the protection and external-control registers read 0, `irq_o` is 0, and the vector (offset 0x00) reads 0.
- R2: For sources 1..95, the pending bit equals the source input sampled at the previous rising edge, unless that bit was cleared in the same cycle. Source k sits in bank k/32 at bit k%32. Pending banks are at 0x10, 0x14 and 0x18.
- R3: Writing a pending bank clears each bit whose write-data bit is 1 and leaves bits written 0 unchanged. Writing 0xFFFFFFFF clears the whole bank.
- R4: Source 0 (`src_i[0]`) sets pending bit 0 on a rising edge of the input and keeps it set after the input falls, until software writes 1 to bit 0 of bank 0. A rising edge in the same cycle as that clear leaves the bit set.
- R5: A source with its enable bit 0 affects neither `irq_o` nor the vector. Enable banks are at 0x40, 0x44 and 0x48.
- R6: A source whose mask bit is 1 is blocked from `irq_o` and the vector even when it is enabled. Mask banks are at 0x50, 0x54 and 0x58.
- R7: Reading 0x00 returns the lowest-numbered pending, enabled and unmasked source number in bits [8:2], with all other bits 0. It returns 0 when no source is active.
- R8: `irq_o` is 1 exactly when at least one source is pending, enabled and unmasked.
- R9: The protection register at 0x08 keeps bit 0 of the written data, and the external-control register at 0x0C keeps bits [1:0]. All other bits of both read 0.
- R10: The FIQ pending banks at 0x20, 0x24 and 0x28 read the same value as the pending banks.
- R11: The enable and mask banks read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 96 | Interrupt sources; bit 0 is the edge-captured external input |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Two functions can act on pending bit 0 in the same cycle: the write-one clear from software and the capture of a fresh rising edge on the external input. The bench first latches source 0 and lowers the input. On a single falling edge it then raises the input again and issues the clear, and it expects bit 0 to read 1 afterwards. A second case issues the clear with no edge, and that case must read 0. The level sources pose a smaller version of the same conflict: a clear written while the input stays high must read 0 for one cycle and 1 again the cycle after.

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl #(
  parameter int BANKS  = 3,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [32*BANKS-1:0]  src_i,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic                 irq_o
);
  localparam int NSRC  = 32 * BANKS;
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]  pend, en, msk, clr, active;
  logic             nmi_q, prot;
  logic [1:0]       xctl;
  logic [IDX_W-1:0] vec_idx;

  wire nmi_rise = src_i[0] & ~nmi_q;

  always_comb begin
    clr = '0;
    for (int b = 0; b < BANKS; b++)
      if (wr_en && addr == ADDR_W'(16 + 4*b)) clr[b*32 +: 32] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      nmi_q <= 1'b0;
    end else begin
      nmi_q         <= src_i[0];
      pend[NSRC-1:1] <= src_i[NSRC-1:1] & ~clr[NSRC-1:1];
      pend[0]       <= (pend[0] & ~clr[0]) | nmi_rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      msk  <= '0;
      prot <= 1'b0;
      xctl <= 2'b00;
    end else if (wr_en) begin
      if (addr == ADDR_W'(8'h08)) prot <= wdata[0];
      if (addr == ADDR_W'(8'h0C)) xctl <= wdata[1:0];
      for (int b = 0; b < BANKS; b++) begin
        if (addr == ADDR_W'(64 + 4*b)) en[b*32 +: 32]  <= wdata;
        if (addr == ADDR_W'(80 + 4*b)) msk[b*32 +: 32] <= wdata;
      end
    end
  end

  assign active = pend & en & ~msk;
  assign irq_o  = |active;

  always_comb begin
    vec_idx = '0;
    for (int k = NSRC-1; k >= 0; k--)
      if (active[k]) vec_idx = IDX_W'(k);
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(8'h00)) rdata[IDX_W+1:2] = vec_idx;
    if (addr == ADDR_W'(8'h08)) rdata[0] = prot;
    if (addr == ADDR_W'(8'h0C)) rdata[1:0] = xctl;
    for (int b = 0; b < BANKS; b++) begin
      if (addr == ADDR_W'(16 + 4*b)) rdata = pend[b*32 +: 32];
      if (addr == ADDR_W'(32 + 4*b)) rdata = pend[b*32 +: 32];
      if (addr == ADDR_W'(64 + 4*b)) rdata = en[b*32 +: 32];
      if (addr == ADDR_W'(80 + 4*b)) rdata = msk[b*32 +: 32];
    end
  end

  // R4
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] && !clr[0]) |=> pend[0]);
  // R4
  nmi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_rise |=> pend[0]);
  // R3
  lvl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr[NSRC-1:1]) |=> ((pend[NSRC-1:1] & $past(clr[NSRC-1:1])) == '0));
  // R5
  vec_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en[vec_idx] && pend[vec_idx]));
  // R6
  vec_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !msk[vec_idx]);
  // R8
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vec_idx == '0));
endmodule

// File: tb/irq_vector_ctl_tb.sv
module irq_vector_ctl_tb;
  logic        clk = 0, rst_n = 0, wr_en = 0, irq_o;
  logic [95:0] src_i = '0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  int tests = 0, fails = 0;
  bit done = 0;

  irq_vector_ctl u_dut (.clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

  always #2 clk = ~clk;

  // a(7) b(7) en_a en_b mk_a mk_b exp_irq exp_vec(7)
  localparam logic [25:0] TBL [8] = '{
    {7'd5,  7'd40, 1'b1,1'b1,1'b0,1'b0, 1'b1, 7'd5 },
    {7'd5,  7'd40, 1'b0,1'b1,1'b0,1'b0, 1'b1, 7'd40},
    {7'd5,  7'd40, 1'b1,1'b1,1'b1,1'b0, 1'b1, 7'd40},
    {7'd70, 7'd33, 1'b1,1'b1,1'b0,1'b0, 1'b1, 7'd33},
    {7'd95, 7'd64, 1'b1,1'b0,1'b0,1'b0, 1'b1, 7'd95},
    {7'd31, 7'd32, 1'b0,1'b0,1'b0,1'b0, 1'b0, 7'd0 },
    {7'd1,  7'd2,  1'b1,1'b1,1'b0,1'b1, 1'b1, 7'd1 },
    {7'd63, 7'd94, 1'b1,1'b1,1'b1,1'b1, 1'b0, 7'd0 }
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wr96(logic [7:0] base, logic [95:0] v);
    for (int b = 0; b < 3; b++) wr(base + 8'(4*b), v[b*32 +: 32]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [95:0] ev, mv;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    rd(8'h00, d); chk("R1 vector", d, 0);
    rd(8'h08, d); chk("R1 prot", d, 0);
    rd(8'h0C, d); chk("R1 xctl", d, 0);
    for (int b = 0; b < 3; b++) begin
      rd(8'h10 + 8'(4*b), d); chk("R1 pend", d, 0);
      rd(8'h40 + 8'(4*b), d); chk("R1 en", d, 0);
      rd(8'h50 + 8'(4*b), d); chk("R1 mask", d, 0);
    end

    // R5 R6 R7 R8 table walk
    foreach (TBL[i]) begin
      logic [6:0] a, b;
      a = TBL[i][25:19]; b = TBL[i][18:12];
      ev = '0; mv = '0;
      ev[a] = TBL[i][11]; ev[b] = TBL[i][10];
      mv[a] = TBL[i][9];  mv[b] = TBL[i][8];
      wr96(8'h40, ev); wr96(8'h50, mv);
      @(negedge clk); src_i = '0; src_i[a] = 1; src_i[b] = 1;
      @(negedge clk);
      chk("R8 irq table", 32'(irq_o), 32'(TBL[i][7]));
      rd(8'h00, d); chk("R7 vector table", d, {23'd0, TBL[i][6:0], 2'b00});
      src_i = '0;
    end

    // R11 readback
    wr(8'h44, 32'hA5A5_0F0F); rd(8'h44, d); chk("R11 en bank1", d, 32'hA5A5_0F0F);
    wr(8'h58, 32'h1234_5678); rd(8'h58, d); chk("R11 mask bank2", d, 32'h1234_5678);
    wr96(8'h40, '0); wr96(8'h50, '0);

    // R9 protection and external control
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); chk("R9 prot", d, 1);
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, d); chk("R9 xctl", d, 3);
    wr(8'h0C, 32'h0000_0002); rd(8'h0C, d); chk("R9 xctl2", d, 2);

    // R2 level follow, R10 mirror
    @(negedge clk); src_i[35] = 1; src_i[36] = 1;
    @(negedge clk);
    rd(8'h14, d); chk("R2 pend follow", d, 32'h18);
    rd(8'h24, d); chk("R10 fiq mirror", d, 32'h18);
    // R3 clear while level still high: zero for one cycle, then back
    wr(8'h14, 32'h0000_0008);
    rd(8'h14, d); chk("R3 write1 clear", d, 32'h10);
    @(negedge clk); rd(8'h14, d); chk("R3 reassert", d, 32'h18);
    wr(8'h14, 32'h0); rd(8'h14, d); chk("R3 write0 keeps", d, 32'h18);
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, d); chk("R3 clear all", d, 0);
    src_i = '0; @(negedge clk);
    rd(8'h14, d); chk("R2 pend drops", d, 0);

    // R4 external input edge capture and hold
    wr(8'h40, 32'h1);
    @(negedge clk); src_i[0] = 1;
    @(negedge clk); src_i[0] = 0;
    @(negedge clk);
    rd(8'h10, d); chk("R4 latched", d, 1);
    chk("R8 irq nmi", 32'(irq_o), 1);
    rd(8'h00, d); chk("R7 vector zero with src0", d, 0);
    // same-cycle edge and clear: edge wins
    @(negedge clk); src_i[0] = 1; wr_en = 1; addr = 8'h10; wdata = 32'h1;
    @(negedge clk); wr_en = 0;
    rd(8'h10, d); chk("R4 edge beats clear", d, 1);
    wr(8'h10, 32'h1);
    rd(8'h10, d); chk("R4 clear no edge", d, 0);
    chk("R8 irq idle", 32'(irq_o), 0);
    src_i[0] = 0;
    finish_run();
  end
endmodule